// File: doc/BRIEF.md
# Auto-Reload Decrementer

This block is a down-counter that steps once for each time-base tick presented on its tick-enable input. When a tick takes the count from one to zero, the block records an expiry in a status bit. The expiry can drive an interrupt line, and it can make the counter reload itself from a separate reload register, so a periodic event needs no software work between periods.

Software drives the block through simple write strobes. There is one strobe each for the count, the reload value and the control word, plus a clear strobe for the status word. The current count, the reload value and the control and status words are always visible on output ports.

A reload value of zero disables reloading even when auto-reload is enabled. Without a reload, the counter rests at zero and produces no further events until software loads a nonzero count.

Top module: `reload_decrementer`

## Requirements
- R1: After reset the count, the reload value, the control word and the status word are all zero, and `irqOut` is low.
- R2: On each cycle with `tickEn` high and a nonzero count, the count drops by exactly one. Without a tick the count holds.
- R3: An expiry happens only when a tick takes the count from 1 to 0. It sets status bit 27. Loading zero by software, or ticking while the count is already zero, is not an expiry.
- R4: With control bit 22 (auto-reload) set and a nonzero reload value, an expiry loads the count from the reload register in the same cycle, instead of leaving it at zero.
- R5: With auto-reload clear, or with a reload value of zero, the count rests at zero after an expiry. Further ticks leave it at zero and do not set the status bit again.
- R6: `irqOut` is high exactly when status bit 27 and control bit 26 (interrupt enable) are both set.
- R7: A status clear with bit 27 set in `statWrData` clears the status bit. A clear with bit 27 low has no effect. An expiry in the same cycle as a clear leaves the bit set.
- R8: A software count write takes priority over decrement and reload in the same cycle. That cycle produces no expiry.
- R9: The control word stores only bits 26 and 22. All other bits read back as zero.
- R10: Loading a nonzero count after the counter has come to rest re-arms it, so it can expire again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Time-base tick, one decrement per high cycle |
| cntWrEn | input | 1 | Write strobe for the count |
| cntWrData | input | 32 | New count value |
| reloadWrEn | input | 1 | Write strobe for the reload register |
| reloadWrData | input | 32 | New reload value |
| ctrlWrEn | input | 1 | Write strobe for the control word |
| ctrlWrData | input | 32 | Control word (bit 26 interrupt enable, bit 22 auto-reload) |
| statWrEn | input | 1 | Write-one-to-clear strobe for the status word |
| statWrData | input | 32 | Clear mask (bit 27 clears expiry status) |
| countOut | output | 32 | Current count |
| reloadOut | output | 32 | Current reload value |
| ctrlOut | output | 32 | Stored control word |
| statusOut | output | 32 | Status word, bit 27 is expiry status |
| irqOut | output | 1 | Decrementer interrupt request |

## Verification
The hardest cases to reach are the same-cycle collisions: an expiry coinciding with a status clear, and a tick coinciding with a software count write. The bench reaches them by first parking the count at one. It then drives the tick together with the competing strobe in one cycle, from a single falling edge. The zero-reload case needs auto-reload enabled with the reload register at zero, followed by a long run of ticks to show that the count and the status bit both stay at rest.

// File: rtl/decr_pkg.sv
package decr_pkg;
  localparam int CNT_W   = 32;
  localparam int REG_W   = 32;

  typedef struct packed {
    logic load;
    logic decrement;
    logic reload;
    logic expire;
  } decr_strobe_t;
endpackage

// File: rtl/decr_datapath.sv
module decr_datapath
  import decr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  decr_strobe_t strb,
  input  logic [W-1:0] cntWrData,
  input  logic         reloadWrEn,
  input  logic [W-1:0] reloadWrData,
  output logic [W-1:0] countOut,
  output logic [W-1:0] reloadOut,
  output logic         countIsZero,
  output logic         countIsOne,
  output logic         reloadIsZero
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] countReg;
  logic [W-1:0] reloadReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
    end else if (strb.load) begin
      countReg <= cntWrData;
    end else if (strb.reload) begin
      countReg <= reloadReg;
    end else if (strb.decrement) begin
      countReg <= countReg - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= '0;
    end else if (reloadWrEn) begin
      reloadReg <= reloadWrData;
    end
  end

  assign countOut     = countReg;
  assign reloadOut    = reloadReg;
  assign countIsZero  = (countReg == '0);
  assign countIsOne   = (countReg == ONE);
  assign reloadIsZero = (reloadReg == '0);

  // R5: a resting counter stays at zero unless software loads it
  a_r5_rest_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    (countIsZero && !strb.load) |=> countIsZero);

  // R8: software load wins over every other update
  a_r8_load_priority: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (countOut == $past(cntWrData)));

  // R4: a reload is never requested from an empty reload register
  a_r4_no_zero_reload: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |-> !reloadIsZero);

  // R4: reload takes the stored reload value
  a_r4_reload_value: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> (countOut == $past(reloadReg)));

  // R5: expiry without reload leaves the count at zero
  a_r5_expire_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.expire && !strb.reload) |=> countIsZero);
endmodule

// File: rtl/decr_control.sv
module decr_control
  import decr_pkg::*;
#(
  parameter int RW          = REG_W,
  parameter int IRQ_EN_BIT  = 26,
  parameter int AUTO_BIT    = 22,
  parameter int STAT_BIT    = 27
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          cntWrEn,
  input  logic          ctrlWrEn,
  input  logic [RW-1:0] ctrlWrData,
  input  logic          statWrEn,
  input  logic [RW-1:0] statWrData,
  input  logic          countIsZero,
  input  logic          countIsOne,
  input  logic          reloadIsZero,
  output decr_strobe_t  strb,
  output logic [RW-1:0] ctrlOut,
  output logic [RW-1:0] statusOut,
  output logic          irqOut
);
  localparam logic [RW-1:0] CTRL_MASK = (RW'(1) << IRQ_EN_BIT) | (RW'(1) << AUTO_BIT);
  localparam logic [RW-1:0] STAT_MASK = RW'(1) << STAT_BIT;

  logic irqEnReg;
  logic autoReg;
  logic statReg;
  logic clearReq;

  always_comb begin
    strb.load      = cntWrEn;
    strb.expire    = tickEn && countIsOne && !cntWrEn;
    strb.reload    = strb.expire && autoReg && !reloadIsZero;
    strb.decrement = tickEn && !countIsZero && !cntWrEn && !strb.reload;
  end

  assign clearReq = statWrEn && statWrData[STAT_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnReg <= 1'b0;
      autoReg  <= 1'b0;
    end else if (ctrlWrEn) begin
      irqEnReg <= ctrlWrData[IRQ_EN_BIT];
      autoReg  <= ctrlWrData[AUTO_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= 1'b0;
    end else if (strb.expire) begin
      statReg <= 1'b1;
    end else if (clearReq) begin
      statReg <= 1'b0;
    end
  end

  always_comb begin
    ctrlOut             = '0;
    ctrlOut[IRQ_EN_BIT] = irqEnReg;
    ctrlOut[AUTO_BIT]   = autoReg;
    statusOut           = '0;
    statusOut[STAT_BIT] = statReg;
  end

  assign irqOut = statReg && irqEnReg;

  // R3: an expiry is recorded in the status word
  a_r3_expire_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    strb.expire |=> statusOut[STAT_BIT]);

  // R3: status only rises after an expiry
  a_r3_status_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[STAT_BIT]) |-> $past(strb.expire));

  // R7: a matching clear without a new expiry empties the status
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (statWrEn && ((statWrData & STAT_MASK) != '0) && !strb.expire) |=> (statusOut == '0));

  // R9: only the defined control bits are kept
  a_r9_ctrl_mask: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> (ctrlOut == ($past(ctrlWrData) & CTRL_MASK)));

  // R6: no interrupt while disabled
  a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlOut[IRQ_EN_BIT] |-> !irqOut);

  // R8: no expiry in a cycle that carries a software load
  a_r8_no_expire_on_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !strb.expire);
endmodule

// File: rtl/reload_decrementer.sv
module reload_decrementer
  import decr_pkg::*;
#(
  parameter int W          = CNT_W,
  parameter int RW         = REG_W,
  parameter int IRQ_EN_BIT = 26,
  parameter int AUTO_BIT   = 22,
  parameter int STAT_BIT   = 27
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          cntWrEn,
  input  logic [W-1:0]  cntWrData,
  input  logic          reloadWrEn,
  input  logic [W-1:0]  reloadWrData,
  input  logic          ctrlWrEn,
  input  logic [RW-1:0] ctrlWrData,
  input  logic          statWrEn,
  input  logic [RW-1:0] statWrData,
  output logic [W-1:0]  countOut,
  output logic [W-1:0]  reloadOut,
  output logic [RW-1:0] ctrlOut,
  output logic [RW-1:0] statusOut,
  output logic          irqOut
);
  decr_strobe_t strb;
  logic countIsZero;
  logic countIsOne;
  logic reloadIsZero;

  decr_control #(
    .RW(RW), .IRQ_EN_BIT(IRQ_EN_BIT), .AUTO_BIT(AUTO_BIT), .STAT_BIT(STAT_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntWrEn(cntWrEn),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .statWrEn(statWrEn), .statWrData(statWrData),
    .countIsZero(countIsZero), .countIsOne(countIsOne), .reloadIsZero(reloadIsZero),
    .strb(strb), .ctrlOut(ctrlOut), .statusOut(statusOut), .irqOut(irqOut)
  );

  decr_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cntWrData(cntWrData),
    .reloadWrEn(reloadWrEn), .reloadWrData(reloadWrData),
    .countOut(countOut), .reloadOut(reloadOut),
    .countIsZero(countIsZero), .countIsOne(countIsOne), .reloadIsZero(reloadIsZero)
  );

  // R2: a plain tick on a nonzero count lowers it by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !cntWrEn && (countOut > W'(1))) |=> (countOut == $past(countOut) - W'(1)));

  // R2: without tick or write the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !cntWrEn) |=> $stable(countOut));
endmodule

// File: tb/reload_decrementer_test.sv
module reload_decrementer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IE  = 32'h1 << 26;
  localparam logic [31:0] ARE = 32'h1 << 22;
  localparam logic [31:0] ST  = 32'h1 << 27;

  logic clk = 0;
  logic rstN = 0;
  logic tickEn = 0, cntWrEn = 0, reloadWrEn = 0, ctrlWrEn = 0, statWrEn = 0;
  logic [31:0] cntWrData = 0, reloadWrData = 0, ctrlWrData = 0, statWrData = 0;
  logic [31:0] countOut, reloadOut, ctrlOut, statusOut;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_decrementer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .reloadWrEn(reloadWrEn), .reloadWrData(reloadWrData),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .statWrEn(statWrEn), .statWrData(statWrData),
    .countOut(countOut), .reloadOut(reloadOut), .ctrlOut(ctrlOut),
    .statusOut(statusOut), .irqOut(irqOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic loadCount(logic [31:0] v);
    @(negedge clk); cntWrEn = 1; cntWrData = v;
    @(negedge clk); cntWrEn = 0;
  endtask
  task automatic loadReload(logic [31:0] v);
    @(negedge clk); reloadWrEn = 1; reloadWrData = v;
    @(negedge clk); reloadWrEn = 0;
  endtask
  task automatic writeCtrl(logic [31:0] v);
    @(negedge clk); ctrlWrEn = 1; ctrlWrData = v;
    @(negedge clk); ctrlWrEn = 0;
  endtask
  task automatic clearStat(logic [31:0] v);
    @(negedge clk); statWrEn = 1; statWrData = v;
    @(negedge clk); statWrEn = 0;
  endtask
  task automatic ticks(int n);
    @(negedge clk); tickEn = 1;
    repeat (n) @(negedge clk);
    tickEn = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
  endtask

  task automatic testReset();
    doReset();
    check("R1 count", countOut, 0);
    check("R1 reload", reloadOut, 0);
    check("R1 ctrl", ctrlOut, 0);
    check("R1 status", statusOut, 0);
    check("R1 irq", {31'b0, irqOut}, 0);
  endtask

  task automatic testCountdown();
    loadCount(5);
    ticks(3);
    check("R2 after three ticks", countOut, 2);
    repeat (4) @(negedge clk);
    check("R2 hold without tick", countOut, 2);
    check("R3 no expiry yet", statusOut, 0);
  endtask

  task automatic testOneShot();
    writeCtrl(0);
    loadCount(2);
    ticks(2);
    check("R3 reached zero", countOut, 0);
    check("R3 status set", statusOut, ST);
    check("R6 irq masked", {31'b0, irqOut}, 0);
    writeCtrl(IE);
    check("R6 irq raised", {31'b0, irqOut}, 1);
    clearStat(~ST);
    check("R7 clear without bit27 ignored", statusOut, ST);
    clearStat(ST);
    check("R7 cleared", statusOut, 0);
    check("R6 irq dropped", {31'b0, irqOut}, 0);
    ticks(6);
    check("R5 rests at zero", countOut, 0);
    check("R5 no refire", statusOut, 0);
  endtask

  task automatic testAutoReload();
    writeCtrl(IE | ARE);
    loadReload(4);
    loadCount(2);
    ticks(2);
    check("R4 reloaded", countOut, 4);
    check("R4 status", statusOut, ST);
    check("R6 irq on", {31'b0, irqOut}, 1);
    clearStat(ST);
    ticks(4);
    check("R4 period repeats count", countOut, 4);
    check("R4 period repeats status", statusOut, ST);
    clearStat(ST);
  endtask

  task automatic testZeroReload();
    writeCtrl(ARE);
    loadReload(0);
    loadCount(1);
    ticks(1);
    check("R5 zero reload count", countOut, 0);
    check("R5 zero reload status", statusOut, ST);
    clearStat(ST);
    ticks(8);
    check("R5 zero reload rests", countOut, 0);
    check("R5 zero reload no refire", statusOut, 0);
  endtask

  task automatic testRearm();
    writeCtrl(0);
    loadCount(0);
    ticks(3);
    check("R3 zero load no event", statusOut, 0);
    loadCount(3);
    ticks(3);
    check("R10 rearmed count", countOut, 0);
    check("R10 rearmed status", statusOut, ST);
    clearStat(ST);
  endtask

  task automatic testPriority();
    writeCtrl(ARE);
    loadReload(7);
    loadCount(1);
    @(negedge clk); tickEn = 1; cntWrEn = 1; cntWrData = 9;
    @(negedge clk); tickEn = 0; cntWrEn = 0;
    check("R8 write wins", countOut, 9);
    check("R8 no expiry", statusOut, 0);
  endtask

  task automatic testClearCollision();
    writeCtrl(0);
    loadCount(1);
    ticks(1);
    check("R7 precondition", statusOut, ST);
    loadCount(1);
    @(negedge clk); tickEn = 1; statWrEn = 1; statWrData = ST;
    @(negedge clk); tickEn = 0; statWrEn = 0;
    check("R7 expiry beats clear", statusOut, ST);
    clearStat(ST);
  endtask

  task automatic testCtrlMask();
    writeCtrl(32'hFFFF_FFFF);
    check("R9 control mask", ctrlOut, IE | ARE);
    doReset();
    check("R1 ctrl after reset", ctrlOut, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testCountdown();
    testOneShot();
    testAutoReload();
    testZeroReload();
    testRearm();
    testPriority();
    testClearCollision();
    testCtrlMask();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule